// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side sequencer for a clocked burst read port on a memory array with 32-bit words. The host pulls an address-valid strobe low at a clock edge, and the block captures the start address at that edge. It then waits a programmable number of clocks and delivers one word per clock from the array. The array is modelled as a plain lookup port: the block drives a word address, and the array returns that word's data in the same cycle.

Finite bursts of 2, 4 or 8 words walk upward through an aligned window and wrap back to the window's base. An active-low end-of-burst flag marks the final word. A continuous mode walks linearly without bound. In that mode an active-low wait output reports when no word is on the outputs: during the first-access latency, and for a one-clock row-fetch stall each time the address enters a new 16-word row. Chip enable and output enable gate the outputs combinationally. Dropping chip enable also abandons the burst in progress.

Top module: `burst_read_seq`

## Requirements
- R1: A clock edge with `cfgWrite` high stores `cfgLen` and `cfgLatency`. `cfgLen` codes are 2'b00 = continuous, 2'b01 = 2 words, 2'b10 = 4 words, 2'b11 = 8 words. After reset the setting is 4 words with latency 5. A burst uses the setting held at its address-capture edge.
- R2: An edge with `advN` low and `ceN` low captures `addrIn` and starts a burst. This also happens during a running burst, which is then dropped in favour of the new address with the full latency.
- R3: With latency L (1 to 7), the first word is on `dataOut` after the L-th edge following the capture edge. Before that edge `dataOut` is zero. A latency setting of 0 behaves as 1.
- R4: Each later word of a burst appears one clock after the previous one.
- R5: In a finite burst of N words from address A, word i comes from address (A with its low log2(N) bits cleared) plus ((A + i) mod N).
- R6: In a finite burst, `endOfBurstN` is low exactly while the last word is on `dataOut`. After that word, `dataOut` returns to zero.
- R7: In continuous mode the address rises by one per word without wrapping, and `endOfBurstN` stays high.
- R8: In continuous mode, `waitN` is low during the initial latency. It is also low for one inserted clock, with `dataOut` zero, before any word other than the first whose address has its low 4 bits zero. `waitN` is high whenever a word is shown, and always high in finite mode.
- R9: While `oeN` is high, `dataOut` is zero and both `endOfBurstN` and `waitN` are high. The burst keeps advancing, so the word shown when `oeN` returns low is the one due in that cycle.
- R10: While `ceN` is high, `dataOut` is zero and the flags are high. Any edge with `ceN` high ends the burst for good, and `advN` is ignored at such edges.
- R11: After reset, with the enables low and no strobe, `dataOut` is zero and both flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgLen | input | 2 | Burst length code |
| cfgLatency | input | 3 | First-access latency in clocks |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| advN | input | 1 | Active-low address-valid strobe |
| addrIn | input | ADDR_W (20) | Burst start word address |
| arrayAddr | output | ADDR_W (20) | Word address presented to the array |
| arrayData | input | DATA_W (32) | Array word for `arrayAddr` |
| dataOut | output | DATA_W (32) | Burst data, zero when idle or disabled |
| endOfBurstN | output | 1 | Low while the last finite-burst word is shown |
| waitN | output | 1 | Low while a continuous burst has no word to show |

## Verification
The bench builds the block with its defaults: a 20-bit address, 32-bit data, a 3-bit latency field and a 16-word row. The array model returns each word's own address under a fixed tag, so every beat shows which address the block fetched. The 3-bit latency field allows both the longest default-style latency and the zero-to-one clamp. The 16-word row makes a continuous burst cross a row boundary within a few beats of a start just below it. The 20-bit address leaves room for windows starting mid-row at 0x1D and 0x006, so wrapping shows up in 2-, 4- and 8-word bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int WRAP_W = 3;

  typedef enum logic [1:0] {
    LEN_CONT = 2'b00,
    LEN_2    = 2'b01,
    LEN_4    = 2'b10,
    LEN_8    = 2'b11
  } burstLen_e;

  typedef struct packed {
    logic capture;
    logic load;
    logic last;
  } seqStrobe_t;

  function automatic logic [WRAP_W-1:0] windowMask(burstLen_e len);
    case (len)
      LEN_2:   return 3'd1;
      LEN_4:   return 3'd3;
      LEN_8:   return 3'd7;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LAT_W   = 3,
  parameter int DEF_LAT = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                advN,
  input  logic                cfgWrite,
  input  logic [1:0]          cfgLen,
  input  logic [LAT_W-1:0]    cfgLatency,
  input  logic                atRowStart,
  output seqStrobe_t          strb,
  output logic [WRAP_W-1:0]   wrapMask,
  output logic                burstActive,
  output logic                contMode
);
  burstLen_e         lenReg, modeReg;
  logic [LAT_W-1:0]  latReg, latCnt, latLoad;
  logic [WRAP_W-1:0] beatCnt;
  logic              firstBeat, stalled, stallNeeded;

  always_comb begin
    latLoad        = (latReg == '0) ? '0 : latReg - 1'b1;
    wrapMask       = windowMask(modeReg);
    contMode       = (modeReg == LEN_CONT);
    strb.capture   = !ceN && !advN;
    stallNeeded    = burstActive && (latCnt == '0) && contMode && !firstBeat &&
                     atRowStart && !stalled;
    strb.load      = burstActive && !ceN && !strb.capture && (latCnt == '0) && !stallNeeded;
    strb.last      = strb.load && !contMode && (beatCnt == wrapMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg      <= LEN_4;
      latReg      <= LAT_W'(DEF_LAT);
      modeReg     <= LEN_CONT;
      burstActive <= 1'b0;
      latCnt      <= '0;
      beatCnt     <= '0;
      firstBeat   <= 1'b0;
      stalled     <= 1'b0;
    end else begin
      if (cfgWrite) begin
        lenReg <= burstLen_e'(cfgLen);
        latReg <= cfgLatency;
      end
      if (ceN) begin
        burstActive <= 1'b0;
        stalled     <= 1'b0;
      end else if (strb.capture) begin
        burstActive <= 1'b1;
        latCnt      <= latLoad;
        beatCnt     <= '0;
        firstBeat   <= 1'b1;
        stalled     <= 1'b0;
        modeReg     <= lenReg;
      end else if (burstActive) begin
        if (latCnt != '0) begin
          latCnt <= latCnt - 1'b1;
        end else if (stallNeeded) begin
          stalled <= 1'b1;
        end else begin
          beatCnt   <= beatCnt + 1'b1;
          firstBeat <= 1'b0;
          stalled   <= 1'b0;
          if (strb.last) burstActive <= 1'b0;
        end
      end
    end
  end

  // R2/R3: a capture arms the latency counter from the stored setting
  a_r3_latency_armed: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !advN) |=> (burstActive && latCnt == $past(latLoad)));

  // R10: chip enable high always ends the burst
  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !burstActive);

  // R8: a row-fetch stall lasts one clock only
  a_r8_stall_single: assert property (@(posedge clk) disable iff (!rstN)
    stalled |=> !stalled);
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int ROW_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [WRAP_W-1:0] wrapMask,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] arrayData,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              atRowStart,
  output logic [DATA_W-1:0] dataReg,
  output logic              validReg,
  output logic              lastReg
);
  logic [ADDR_W-1:0] curAddr, nextAddr, maskWide, bumped;

  always_comb begin
    maskWide   = {{(ADDR_W-WRAP_W){1'b0}}, wrapMask};
    bumped     = curAddr + 1'b1;
    nextAddr   = (curAddr & ~maskWide) | (bumped & maskWide);
    if (wrapMask == '0) nextAddr = bumped;
    arrayAddr  = curAddr;
    atRowStart = (curAddr[ROW_BITS-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      dataReg  <= '0;
      validReg <= 1'b0;
      lastReg  <= 1'b0;
    end else begin
      if (strb.capture)   curAddr <= addrIn;
      else if (strb.load) curAddr <= nextAddr;
      dataReg  <= strb.load ? arrayData : '0;
      validReg <= strb.load;
      lastReg  <= strb.last;
    end
  end

  // R5: a finite burst never leaves its aligned window
  a_r5_window: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.capture && wrapMask != '0) |=>
      ((curAddr & ~$past(maskWide)) == ($past(curAddr) & ~$past(maskWide))));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int LAT_W    = 3,
  parameter int DEF_LAT  = 5,
  parameter int ROW_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgLen,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              endOfBurstN,
  output logic              waitN
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);

  seqStrobe_t        strb;
  logic [WRAP_W-1:0] wrapMask;
  logic              burstActive, contMode, atRowStart;
  logic [DATA_W-1:0] dataReg;
  logic              validReg, lastReg, outEnabled;

  burst_seq_ctrl #(.LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .advN(advN), .cfgWrite(cfgWrite),
    .cfgLen(cfgLen), .cfgLatency(cfgLatency), .atRowStart(atRowStart),
    .strb(strb), .wrapMask(wrapMask), .burstActive(burstActive), .contMode(contMode)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrapMask(wrapMask), .addrIn(addrIn),
    .arrayData(arrayData), .arrayAddr(arrayAddr), .atRowStart(atRowStart),
    .dataReg(dataReg), .validReg(validReg), .lastReg(lastReg)
  );

  always_comb begin
    outEnabled  = !ceN && !oeN;
    dataOut     = outEnabled ? dataReg : '0;
    endOfBurstN = !(outEnabled && lastReg);
    waitN       = !(outEnabled && burstActive && contMode && !validReg);
  end

  // R6: the end-of-burst flag marks a single beat
  a_r6_last_single: assert property (@(posedge clk) disable iff (!rstN)
    !endOfBurstN |=> endOfBurstN);
endmodule

// File: tb/burst_read_seq_tb.sv
module burst_read_seq_tb;
  logic        clk = 1'b0;
  logic        rstN, cfgWrite, ceN, oeN, advN;
  logic [1:0]  cfgLen;
  logic [2:0]  cfgLatency;
  logic [19:0] addrIn, arrayAddr;
  logic [31:0] arrayData, dataOut;
  logic        endOfBurstN, waitN;
  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  always_comb arrayData = {12'hC5A, arrayAddr};

  burst_read_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgLen(cfgLen), .cfgLatency(cfgLatency),
    .ceN(ceN), .oeN(oeN), .advN(advN), .addrIn(addrIn), .arrayAddr(arrayAddr),
    .arrayData(arrayData), .dataOut(dataOut), .endOfBurstN(endOfBurstN), .waitN(waitN)
  );

  function automatic logic [31:0] wordAt(logic [19:0] a);
    return {12'hC5A, a};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectOut(string req, logic [31:0] d, bit eob, bit wt);
    check(dataOut === d, {req, " data"}, dataOut, d);
    check(endOfBurstN === eob, {req, " endOfBurstN"}, 32'(endOfBurstN), 32'(eob));
    check(waitN === wt, {req, " waitN"}, 32'(waitN), 32'(wt));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeCfg(logic [1:0] len, logic [2:0] lat);
    cfgWrite = 1'b1; cfgLen = len; cfgLatency = lat;
    step();
    cfgWrite = 1'b0;
  endtask

  task automatic pulse(logic [19:0] a);
    advN = 1'b0; addrIn = a;
    step();
    advN = 1'b1; addrIn = '0;
  endtask

  // finite burst of n words, latency latEff; checks R3, R4, R5, R6
  task automatic finiteBurst(string req, logic [19:0] a, int latEff, int n);
    logic [19:0] base, exp;
    pulse(a);
    for (int i = 1; i < latEff; i++) begin
      expectOut({req, " R3 latency"}, 32'h0, 1'b1, 1'b1);
      step();
    end
    expectOut({req, " R3 pre-first"}, 32'h0, 1'b1, 1'b1);
    base = a & ~20'(n - 1);
    for (int i = 0; i < n; i++) begin
      step();
      exp = base | ((a + 20'(i)) & 20'(n - 1));
      expectOut({req, " R4 R5 R6 beat"}, wordAt(exp), (i != n - 1), 1'b1);
    end
    step();
    expectOut({req, " R6 after last"}, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic tResetState();
    expectOut("R11 reset", 32'h0, 1'b1, 1'b1);
  endtask

  task automatic tDefaults();
    finiteBurst("R1 default 4w", 20'h00006, 5, 4);
  endtask

  task automatic tLengths();
    writeCfg(2'b11, 3'd4);
    finiteBurst("R1 8w", 20'h0001D, 4, 8);
    writeCfg(2'b01, 3'd5);
    finiteBurst("R1 2w", 20'h00003, 5, 2);
    writeCfg(2'b01, 3'd0);
    finiteBurst("R3 lat0", 20'h00011, 1, 2);
  endtask

  task automatic tContinuous();
    writeCfg(2'b00, 3'd5);
    pulse(20'h0000E);
    for (int i = 1; i <= 5; i++) begin
      expectOut("R8 cont latency wait", 32'h0, 1'b1, 1'b0);
      if (i < 5) step();
    end
    step(); expectOut("R7 cont E", wordAt(20'h0000E), 1'b1, 1'b1);
    step(); expectOut("R7 cont F", wordAt(20'h0000F), 1'b1, 1'b1);
    step(); expectOut("R8 row stall", 32'h0, 1'b1, 1'b0);
    step(); expectOut("R7 cont 10", wordAt(20'h00010), 1'b1, 1'b1);
    step(); expectOut("R7 cont 11", wordAt(20'h00011), 1'b1, 1'b1);
    ceN = 1'b1; step(); ceN = 1'b0;
    step(); expectOut("R10 cont ended", 32'h0, 1'b1, 1'b1);
  endtask

  task automatic tOutputEnable();
    writeCfg(2'b11, 3'd4);
    pulse(20'h00020);
    repeat (4) step();
    expectOut("R9 first", wordAt(20'h00020), 1'b1, 1'b1);
    oeN = 1'b1;
    #1 expectOut("R9 oe high", 32'h0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(); expectOut("R9 hidden", 32'h0, 1'b1, 1'b1);
    end
    oeN = 1'b0;
    #1 expectOut("R9 resumed", wordAt(20'h00023), 1'b1, 1'b1);
    for (int i = 4; i < 8; i++) begin
      step(); expectOut("R9 tail", wordAt(20'h00020 + 20'(i)), (i != 7), 1'b1);
    end
    step();
  endtask

  task automatic tChipEnable();
    pulse(20'h00040);
    repeat (4) step();
    expectOut("R10 first", wordAt(20'h00040), 1'b1, 1'b1);
    ceN = 1'b1;
    #1 expectOut("R10 ce high", 32'h0, 1'b1, 1'b1);
    step();
    pulse(20'h00050);
    ceN = 1'b0;
    for (int i = 0; i < 10; i++) begin
      expectOut("R10 aborted", 32'h0, 1'b1, 1'b1);
      step();
    end
  endtask

  task automatic tRestart();
    writeCfg(2'b10, 3'd5);
    pulse(20'h00100);
    step(); step();
    finiteBurst("R2 restart", 20'h00208, 5, 4);
  endtask

  initial begin
    rstN = 1'b0; cfgWrite = 1'b0; cfgLen = 2'b10; cfgLatency = 3'd5;
    ceN = 1'b0; oeN = 1'b0; advN = 1'b1; addrIn = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    tResetState();
    tDefaults();
    tLengths();
    tContinuous();
    tOutputEnable();
    tChipEnable();
    tRestart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule